// File: doc/BRIEF.md
# Cushion-Ordered Push-In Arbitrary-Out Cell Queue

This block keeps the waiting cells of one switch input in a single ordered list. Each cell carries a destination port, a time-to-leave value and a payload tag. When a cell is offered, the caller also supplies its output cushion X, which is the number of cells already waiting at the destination output that must leave before it. The block places the new cell so that exactly X queued cells stand ahead of it. If fewer than X cells are queued, the new cell goes to the back. Once a cell is placed, the order among queued cells never changes.

A scheduler may take out any cell by naming its position, so cells can leave from the middle of the list as well as from the head. The whole list is always visible in parallel. For every slot the block shows a valid bit, the stored fields, and the slot's input thread, which is the number of cells ahead of it. Storage is compacted: slot k holds the cell with k cells ahead of it. A removal and an insertion may happen in the same cycle. The removal is applied first, and the insertion position is then taken on the compacted list.

Occupancy is tracked by a three-state machine:
- Q_EMPTY: no cells are held.
- Q_PARTIAL: some slots are free.
- Q_FULL: every slot is used.

Its transitions are:
- FILL: from Q_EMPTY to Q_PARTIAL.
- TOP_OFF: from Q_PARTIAL to Q_FULL.
- DRAIN_SOME: from Q_FULL to Q_PARTIAL.
- EMPTY_OUT: from Q_PARTIAL to Q_EMPTY.
- HOLD: the state stays the same.

Direct jumps are possible only with a depth of one. The state drives the empty and full flags.

Top module: `piao_queue`

## Requirements
- R1: After reset the queue holds no cells: count is 0, empty is 1, full is 0, every slot_valid bit is 0, and ins_rej and rm_err are 0.
- R2: An accepted insert whose cushion X is below the current occupancy places the cell at slot X, one cycle after the request. Cells that were at slot X or later move back by one slot.
- R3: An accepted insert whose cushion X is equal to or above the current occupancy places the cell at the tail slot, which is at index count.
- R4: Queued cells never change their relative order under any mix of inserts, removals and idle cycles. With no request, the contents and the count stay unchanged.
- R5: A removal of slot i, where i is below count, takes out exactly that cell. Later cells move forward by one slot, and count drops by one.
- R6: Slot k reports slot_valid equal to (k < count) and slot_thread equal to k, its number of cells ahead. Fields are packed per slot at bits [k*W +: W].
- R7: An insert while full with no removal in the same cycle is rejected. The queue stays unchanged, and ins_rej is 1 for the next cycle only.
- R8: When an insert and a valid removal coincide, the removal is applied first. The insert position is then computed against the reduced occupancy, so an insert while full succeeds if a removal accompanies it.
- R9: A removal naming an index equal to or above count is ignored: the contents and count stay unchanged, and rm_err is 1 for the next cycle only.
- R10: count is always between 0 and DEPTH. empty is 1 exactly when count is 0, and full is 1 exactly when count equals DEPTH. count rises by one for an accepted insert without a removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_dest | input | PORT_W | Destination port of the offered cell |
| ins_ttl | input | TTL_W | Time-to-leave of the offered cell |
| ins_tag | input | TAG_W | Payload tag of the offered cell |
| ins_cushion | input | CUSH_W | Output cushion, i.e. how many cells go ahead |
| rm_valid | input | 1 | Remove request |
| rm_idx | input | IDX_W | Slot to remove |
| slot_valid | output | DEPTH | Per-slot occupied bit |
| slot_dest | output | DEPTH*PORT_W | Per-slot destination |
| slot_ttl | output | DEPTH*TTL_W | Per-slot time-to-leave |
| slot_tag | output | DEPTH*TAG_W | Per-slot payload tag |
| slot_thread | output | DEPTH*IDX_W | Per-slot input thread |
| count | output | CNT_W | Number of queued cells |
| full | output | 1 | All slots used |
| empty | output | 1 | No slot used |
| ins_rej | output | 1 | Previous insert was rejected |
| rm_err | output | 1 | Previous removal named an unused slot |

## Verification
On every cycle the assertions check:
- the link between the count and the empty and full flags;
- the count stepping by one on a lone insert;
- the rejection pulse and frozen count for an insert while full;
- the error pulse for an out-of-range removal;
- that nothing moves on a cycle without requests.

Where an inserted cell actually lands, that survivors keep their order after a removal from the middle, and the remove-then-insert ordering of a shared cycle show only in the bench. The bench shows them by comparing every slot against a behavioural list model after directed cushion cases and a long pseudo-random mix.

// File: rtl/piao_pkg.sv
package piao_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/piao_occ_fsm.sv
module piao_occ_fsm
    import piao_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CUSH_W = 8,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [CUSH_W-1:0] ins_cushion,
    input  logic              rm_valid,
    input  logic [IDX_W-1:0]  rm_idx,
    output logic              rm_ok,
    output logic              ins_ok,
    output logic [CNT_W-1:0]  ins_pos,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              ins_rej,
    output logic              rm_err
);

    occ_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_after, cnt_d;
    logic ins_rej_q, rm_err_q;

    // removal is resolved first; the insert sees the reduced occupancy
    always_comb begin
        rm_ok     = rm_valid && (CNT_W'(rm_idx) < cnt_q);
        cnt_after = cnt_q - CNT_W'(rm_ok);
        ins_ok    = ins_valid && (cnt_after < CNT_W'(DEPTH));
        if (32'(ins_cushion) >= 32'(cnt_after))
            ins_pos = cnt_after;
        else
            ins_pos = CNT_W'(ins_cushion);
        cnt_d = cnt_after + CNT_W'(ins_ok);
    end

    always_comb begin
        if (cnt_d == '0)
            state_d = Q_EMPTY;
        else if (cnt_d == CNT_W'(DEPTH))
            state_d = Q_FULL;
        else
            state_d = Q_PARTIAL;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= Q_EMPTY;
            cnt_q     <= '0;
            ins_rej_q <= 1'b0;
            rm_err_q  <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            ins_rej_q <= ins_valid && !ins_ok;
            rm_err_q  <= rm_valid && !rm_ok;
        end
    end

    // outputs decoded from the state
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state_q)
            Q_EMPTY:   empty = 1'b1;
            Q_PARTIAL: ;
            Q_FULL:    full  = 1'b1;
            default:   empty = 1'b0;
        endcase
    end

    assign count   = cnt_q;
    assign ins_rej = ins_rej_q;
    assign rm_err  = rm_err_q;

endmodule

// File: rtl/piao_reorder.sv
module piao_reorder #(
    parameter int DEPTH = 8,
    parameter int ENT_W = 24,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH*ENT_W-1:0] cur_flat,
    input  logic                   rm_ok,
    input  logic [IDX_W-1:0]       rm_idx,
    input  logic                   ins_ok,
    input  logic [CNT_W-1:0]       ins_pos,
    input  logic [ENT_W-1:0]       ins_ent,
    output logic [DEPTH*ENT_W-1:0] nxt_flat
);

    logic [ENT_W-1:0] cur  [DEPTH+1];
    logic [ENT_W-1:0] comp [DEPTH];

    assign cur[DEPTH] = '0;

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        assign cur[k] = cur_flat[k*ENT_W +: ENT_W];

        // stage one: close the gap left by a removal
        assign comp[k] = (rm_ok && (k >= int'(rm_idx))) ? cur[k+1] : cur[k];

        // stage two: open a gap at the insert position
        if (k == 0) begin : g_head
            assign nxt_flat[k*ENT_W +: ENT_W] =
                (ins_ok && (int'(ins_pos) == k)) ? ins_ent : comp[k];
        end else begin : g_body
            always_comb begin
                if (ins_ok && (int'(ins_pos) == k))
                    nxt_flat[k*ENT_W +: ENT_W] = ins_ent;
                else if (ins_ok && (int'(ins_pos) < k))
                    nxt_flat[k*ENT_W +: ENT_W] = comp[k-1];
                else
                    nxt_flat[k*ENT_W +: ENT_W] = comp[k];
            end
        end
    end

endmodule

// File: rtl/piao_queue.sv
module piao_queue
    import piao_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PORT_W = 4,
    parameter int TTL_W  = 12,
    parameter int TAG_W  = 8,
    parameter int CUSH_W = 8,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ins_valid,
    input  logic [PORT_W-1:0]       ins_dest,
    input  logic [TTL_W-1:0]        ins_ttl,
    input  logic [TAG_W-1:0]        ins_tag,
    input  logic [CUSH_W-1:0]       ins_cushion,
    input  logic                    rm_valid,
    input  logic [IDX_W-1:0]        rm_idx,
    output logic [DEPTH-1:0]        slot_valid,
    output logic [DEPTH*PORT_W-1:0] slot_dest,
    output logic [DEPTH*TTL_W-1:0]  slot_ttl,
    output logic [DEPTH*TAG_W-1:0]  slot_tag,
    output logic [DEPTH*IDX_W-1:0]  slot_thread,
    output logic [CNT_W-1:0]        count,
    output logic                    full,
    output logic                    empty,
    output logic                    ins_rej,
    output logic                    rm_err
);

    localparam int ENT_W = PORT_W + TTL_W + TAG_W;

    logic                   rm_ok, ins_ok;
    logic [CNT_W-1:0]       ins_pos;
    logic [DEPTH*ENT_W-1:0] store_q, store_d;

    piao_occ_fsm #(
        .DEPTH(DEPTH), .CUSH_W(CUSH_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_cushion(ins_cushion),
        .rm_valid(rm_valid), .rm_idx(rm_idx),
        .rm_ok(rm_ok), .ins_ok(ins_ok), .ins_pos(ins_pos),
        .count(count), .full(full), .empty(empty),
        .ins_rej(ins_rej), .rm_err(rm_err)
    );

    piao_reorder #(
        .DEPTH(DEPTH), .ENT_W(ENT_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_reorder (
        .cur_flat(store_q), .rm_ok(rm_ok), .rm_idx(rm_idx),
        .ins_ok(ins_ok), .ins_pos(ins_pos),
        .ins_ent({ins_dest, ins_ttl, ins_tag}),
        .nxt_flat(store_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            store_q <= '0;
        else if (rm_ok || ins_ok)
            store_q <= store_d;
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_view
        assign slot_valid[k]                  = (CNT_W'(k) < count);
        assign slot_tag [k*TAG_W  +: TAG_W ]  = store_q[k*ENT_W +: TAG_W];
        assign slot_ttl [k*TTL_W  +: TTL_W ]  = store_q[k*ENT_W + TAG_W +: TTL_W];
        assign slot_dest[k*PORT_W +: PORT_W]  = store_q[k*ENT_W + TAG_W + TTL_W +: PORT_W];
        assign slot_thread[k*IDX_W +: IDX_W]  = IDX_W'(k);
    end

endmodule

// File: rtl/piao_queue_chk.sv
module piao_queue_chk #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 8,
    parameter int CUSH_W = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ins_valid,
    input logic [CUSH_W-1:0]      ins_cushion,
    input logic                   rm_valid,
    input logic [IDX_W-1:0]       rm_idx,
    input logic [DEPTH*TAG_W-1:0] slot_tag,
    input logic [CNT_W-1:0]       count,
    input logic                   full,
    input logic                   empty,
    input logic                   ins_rej,
    input logic                   rm_err
);

    p_empty_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (count == '0));

    p_full_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full == (count == CNT_W'(DEPTH))) && (count <= CNT_W'(DEPTH)));

    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !full && !rm_valid) |=> (count == $past(count) + 1'b1));

    p_reject_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && full && !rm_valid) |=> (ins_rej && $stable(count) && $stable(slot_tag)));

    p_bad_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_valid && !ins_valid && (CNT_W'(rm_idx) >= count)) |=> (rm_err && $stable(count) && $stable(slot_tag)));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !rm_valid) |=> ($stable(count) && $stable(slot_tag) && !ins_rej && !rm_err));

endmodule

bind piao_queue piao_queue_chk #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .CUSH_W(CUSH_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_cushion(ins_cushion),
    .rm_valid(rm_valid), .rm_idx(rm_idx), .slot_tag(slot_tag), .count(count),
    .full(full), .empty(empty), .ins_rej(ins_rej), .rm_err(rm_err)
);

// File: tb/sim_piao_queue.sv
`timescale 1ns/1ps
module sim_piao_queue;

    localparam int DEPTH = 8, PW = 4, TW = 12, GW = 8, CW = 8;
    localparam int IW = 3, NW = 4, EW = PW + TW + GW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ins_valid = 1'b0, rm_valid = 1'b0;
    logic [PW-1:0] ins_dest = '0;
    logic [TW-1:0] ins_ttl = '0;
    logic [GW-1:0] ins_tag = '0;
    logic [CW-1:0] ins_cushion = '0;
    logic [IW-1:0] rm_idx = '0;
    logic [DEPTH-1:0] slot_valid;
    logic [DEPTH*PW-1:0] slot_dest;
    logic [DEPTH*TW-1:0] slot_ttl;
    logic [DEPTH*GW-1:0] slot_tag;
    logic [DEPTH*IW-1:0] slot_thread;
    logic [NW-1:0] count;
    logic full, empty, ins_rej, rm_err;

    always #2.5 clk = ~clk;

    piao_queue u0 (.*);

    int nchk = 0, nerr = 0;
    bit done = 1'b0;
    logic [EW-1:0] model [$];
    bit exp_rej = 0, exp_err = 0;
    int unsigned seed = 32'h1234_5678;
    int unsigned tagctr = 1;

    task automatic chk(string rq, string what, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic compare(string rq);
        chk("R10", "count", count, model.size());
        chk("R10", "full", full, model.size() == DEPTH);
        chk(rq == "R1" ? "R1" : "R10", "empty", empty, model.size() == 0);
        chk("R7", "ins_rej", ins_rej, exp_rej);
        chk("R9", "rm_err", rm_err, exp_err);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R6", $sformatf("valid[%0d]", k), slot_valid[k], k < model.size());
            chk("R6", $sformatf("thread[%0d]", k), slot_thread[k*IW +: IW], k);
            if (k < model.size())
                chk(rq, $sformatf("slot[%0d]", k),
                    {slot_dest[k*PW +: PW], slot_ttl[k*TW +: TW], slot_tag[k*GW +: GW]},
                    model[k]);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after comparing
    task automatic step(bit iv, int cush, bit rv, int ri, string rq);
        logic [EW-1:0] e;
        int pos;
        ins_valid = iv; ins_cushion = CW'(cush);
        ins_tag = GW'(tagctr); ins_dest = PW'(tagctr * 3); ins_ttl = TW'(tagctr * 17 + 5);
        rm_valid = rv; rm_idx = IW'(ri);
        e = {ins_dest, ins_ttl, ins_tag};
        tagctr++;
        @(posedge clk);
        exp_rej = 0; exp_err = 0;
        if (rv) begin
            if (ri < model.size()) model.delete(ri);
            else exp_err = 1;
        end
        if (iv) begin
            if (model.size() < DEPTH) begin
                pos = (cush >= model.size()) ? model.size() : cush;
                model.insert(pos, e);
            end else exp_rej = 1;
        end
        @(negedge clk);
        compare(rq);
        ins_valid = 0; rm_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        // tail placement for large cushions
        step(1, 200, 0, 0, "R3");
        step(1, 5, 0, 0, "R3");
        step(1, 2, 0, 0, "R3");
        // push-in ahead of existing cells
        step(1, 0, 0, 0, "R2");
        step(1, 2, 0, 0, "R2");
        step(1, 1, 0, 0, "R2");
        step(1, 6, 0, 0, "R3");
        step(1, 3, 0, 0, "R2");
        // full: rejected insert
        step(1, 0, 0, 0, "R7");
        step(1, 9, 0, 0, "R7");
        // idle keeps everything
        step(0, 0, 0, 0, "R4");
        // remove and insert together while full
        step(1, 0, 1, 3, "R8");
        step(1, 7, 1, 7, "R8");
        step(1, 6, 1, 0, "R8");
        // removals from head, middle, tail
        step(0, 0, 1, 0, "R5");
        step(0, 0, 1, 3, "R5");
        step(0, 0, 1, 5, "R5");
        // out-of-range removal ignored
        step(0, 0, 1, 5, "R9");
        step(0, 0, 1, 7, "R9");
        // bad removal with a concurrent insert: insert uses unchanged count
        step(1, 4, 1, 6, "R8");
        // drain to empty
        for (int i = 0; i < 8; i++) step(0, 0, 1, 0, "R5");
        step(0, 0, 1, 0, "R9");
        // pseudo-random mix
        for (int i = 0; i < 600; i++) begin
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
            step(seed[0] | seed[1], int'(seed[6:2]) % 11, seed[7] & seed[8], int'(seed[11:9]), "R4");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule